// File: doc/BRIEF.md
# PC Card Byte and Word Lane Steering

This block sits between the host pins of a 16-bit memory card and the card's internal storage. It turns the two active-low card enables, output enable, write enable, the register-space select, address bit A0, the segment-pair index and the write-protect switch into three things. The first is a set of chip selects for the even and odd memory segments of each pair, plus a select for the attribute store. The second is a direction and a pair of output enables for the low and high data lanes. The third is a lane-swap control that routes an odd byte onto the low lane.

The host reads data bytes from the even and odd segments and the attribute store, and the block places them on the 16-bit host bus. Write data from the host bus goes the other way, to the even and odd segment write ports. All outputs are registered on a system clock, so every decision shows up one cycle after the inputs are sampled. The pair count and the lane width are parameters. The pair index is the group of upper address bits whose top bit is A18.

Top module: `pcl_lane_steer`

## Requirements
- R1: With both card enables high (standby), no segment select, no attribute select, no lane enable, no lane swap and no write enable are asserted.
- R2: With ce1_n low, ce2_n high and a0 low (even byte), only segment 2*p is selected, where p is pair_idx. On a read the low lane carries the even byte, the high lane is off and the swap is off.
- R3: With ce1_n low, ce2_n high and a0 high (odd byte through swap), only segment 2*p+1 is selected and lane_swap is 1. On a read host_dout[7:0] carries the odd byte and the high lane is off. A write sends host_din[7:0] to the odd segment.
- R4: With ce1_n high and ce2_n low (odd byte only), segment 2*p+1 is selected whatever a0 is. On a read only the high lane is on and host_dout[15:8] carries the odd byte. Writes take the odd byte from host_din[15:8].
- R5: With both enables low (word), segments 2*p and 2*p+1 are both selected whatever a0 is. A read enables both lanes, with the even byte on [7:0] and the odd byte on [15:8].
- R6: pair_idx picks the pair: no select bit outside positions 2*p and 2*p+1 is ever set.
- R7: A byte access sets exactly one segment select, and a word access sets exactly two.
- R8: With reg_n low, no segment is selected and only the low lane can be enabled. An even-byte or word access asserts attr_sel and puts attribute data on host_dout[7:0]. Any odd-byte access (a0 high with only ce1_n low, or only ce2_n low) is invalid: it selects nothing, drives no lane and writes nothing.
- R9: With oe_n high, neither lane is enabled and bus_dir is 0. bus_dir is 1 only on a valid read (oe_n low, we_n high).
- R10: wr_en is 1 only for a valid access with we_n low, oe_n high and wp_sw low. Write data is zero when wr_en is 0.
- R11: With oe_n and we_n both low, the cycle is neither a read nor a write: no select, no lane enable and no write enable.
- R12: Reset clears every output. Each output reflects the inputs sampled at the previous rising clock edge and does not change between edges. host_dout is zero on any lane that is not enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce1_n | input | 1 | Low-lane card enable, active low |
| ce2_n | input | 1 | High-lane card enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| reg_n | input | 1 | Attribute space select, active low |
| a0 | input | 1 | Byte address bit 0 |
| pair_idx | input | PAIR_W (2) | Segment pair index from upper address bits |
| wp_sw | input | 1 | Write-protect switch, active high |
| host_din | input | 2*LANE_W (16) | Write data from host bus |
| even_rdata | input | LANE_W (8) | Read data from selected even segment |
| odd_rdata | input | LANE_W (8) | Read data from selected odd segment |
| attr_rdata | input | LANE_W (8) | Read data from attribute store |
| seg_sel | output | 2*NPAIR (8) | Segment selects, bit 2p even and 2p+1 odd of pair p |
| attr_sel | output | 1 | Attribute store select |
| wr_en | output | 1 | Internal write strobe after protection |
| bus_dir | output | 1 | 1 when the card drives the host bus |
| lane_oe_lo | output | 1 | Drive enable for host lane [7:0] |
| lane_oe_hi | output | 1 | Drive enable for host lane [15:8] |
| lane_swap | output | 1 | Odd byte routed through the low lane |
| host_dout | output | 2*LANE_W (16) | Read data toward host bus |
| even_wdata | output | LANE_W (8) | Write data to even segment or attribute store |
| odd_wdata | output | LANE_W (8) | Write data to odd segment |

## Verification
The checker watches, on every cycle, the rules that hold whatever the data: standby and the OE/WE conflict clear everything, a high OE keeps both lanes off, the protect switch keeps the write strobe low, attribute space never touches the high lane or a segment, the odd-only mode never uses the low lane, and the count of active selects stays at one or two. Which segment number is picked, which byte lands on which lane, the swap routing of write data and the one-cycle timing can only be shown by the bench. It sweeps every combination of the control pins, the pair index and the protect switch, with distinct data on each source, and compares against values it computes on its own.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

  // Width mode of a host access, derived from the two card enables and A0.
  typedef enum logic [2:0] {
    ACC_NONE     = 3'd0,
    ACC_EVEN     = 3'd1,
    ACC_ODD_SWAP = 3'd2,
    ACC_ODD_HIGH = 3'd3,
    ACC_WORD     = 3'd4
  } acc_mode_e;

  typedef struct packed {
    acc_mode_e mode;
    logic      valid;
    logic      attr;
    logic      rd;
    logic      wr;
  } acc_ctl_t;

  function automatic acc_mode_e width_mode(input logic ce1_n, input logic ce2_n,
                                           input logic a0);
    acc_mode_e m;
    unique case ({ce1_n, ce2_n})
      2'b00:   m = ACC_WORD;
      2'b01:   m = a0 ? ACC_ODD_SWAP : ACC_EVEN;
      2'b10:   m = ACC_ODD_HIGH;
      default: m = ACC_NONE;
    endcase
    return m;
  endfunction

  function automatic logic is_odd_byte(input acc_mode_e m);
    return (m == ACC_ODD_SWAP) || (m == ACC_ODD_HIGH);
  endfunction

  function automatic logic uses_even_seg(input acc_mode_e m);
    return (m == ACC_EVEN) || (m == ACC_WORD);
  endfunction

  function automatic logic uses_odd_seg(input acc_mode_e m);
    return is_odd_byte(m) || (m == ACC_WORD);
  endfunction

endpackage

// File: rtl/pcl_mode_dec.sv
module pcl_mode_dec
  import pcl_pkg::*;
(
  input  logic     ce1_n,
  input  logic     ce2_n,
  input  logic     oe_n,
  input  logic     we_n,
  input  logic     reg_n,
  input  logic     a0,
  input  logic     wp_sw,
  output acc_ctl_t ctl
);

  acc_mode_e mode;
  logic      strobe_clash;
  logic      attr_odd;
  logic      valid;

  always_comb begin
    mode         = width_mode(ce1_n, ce2_n, a0);
    strobe_clash = !oe_n && !we_n;
    attr_odd     = !reg_n && is_odd_byte(mode);
    valid        = (mode != ACC_NONE) && !strobe_clash && !attr_odd;
  end

  always_comb begin
    ctl.mode  = mode;
    ctl.valid = valid;
    ctl.attr  = valid && !reg_n;
    ctl.rd    = valid && !oe_n && we_n;
    ctl.wr    = valid && oe_n && !we_n && !wp_sw;
  end

endmodule

// File: rtl/pcl_seg_dec.sv
module pcl_seg_dec
  import pcl_pkg::*;
#(
  parameter  int NPAIR  = 4,
  localparam int PAIR_W = $clog2(NPAIR),
  localparam int NSEG   = 2 * NPAIR
) (
  input  acc_ctl_t          ctl,
  input  logic [PAIR_W-1:0] pair_idx,
  output logic [NSEG-1:0]   seg_sel
);

  logic mem_acc;
  logic want_even;
  logic want_odd;

  always_comb begin
    mem_acc   = ctl.valid && !ctl.attr;
    want_even = uses_even_seg(ctl.mode);
    want_odd  = uses_odd_seg(ctl.mode);
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic hit;
    assign hit             = mem_acc && (pair_idx == PAIR_W'(p));
    assign seg_sel[2*p]    = hit && want_even;
    assign seg_sel[2*p+1]  = hit && want_odd;
  end

endmodule

// File: rtl/pcl_lane_mux.sv
module pcl_lane_mux
  import pcl_pkg::*;
#(
  parameter  int LANE_W = 8,
  localparam int BUS_W  = 2 * LANE_W
) (
  input  acc_ctl_t           ctl,
  input  logic [BUS_W-1:0]   host_din,
  input  logic [LANE_W-1:0]  even_rdata,
  input  logic [LANE_W-1:0]  odd_rdata,
  input  logic [LANE_W-1:0]  attr_rdata,
  output logic               oe_lo,
  output logic               oe_hi,
  output logic               swap,
  output logic [BUS_W-1:0]   dout,
  output logic [LANE_W-1:0]  even_wdata,
  output logic [LANE_W-1:0]  odd_wdata
);

  logic [LANE_W-1:0] lo_src;
  logic [LANE_W-1:0] din_lo;
  logic [LANE_W-1:0] din_hi;

  always_comb begin
    din_lo = host_din[LANE_W-1:0];
    din_hi = host_din[BUS_W-1:LANE_W];
    swap   = ctl.valid && !ctl.attr && (ctl.mode == ACC_ODD_SWAP);
    oe_lo  = ctl.rd && (ctl.mode != ACC_ODD_HIGH);
    oe_hi  = ctl.rd && !ctl.attr &&
             ((ctl.mode == ACC_ODD_HIGH) || (ctl.mode == ACC_WORD));
  end

  always_comb begin
    if (swap)          lo_src = odd_rdata;
    else if (ctl.attr) lo_src = attr_rdata;
    else               lo_src = even_rdata;
    dout[LANE_W-1:0]     = oe_lo ? lo_src : '0;
    dout[BUS_W-1:LANE_W] = oe_hi ? odd_rdata : '0;
  end

  always_comb begin
    even_wdata = ctl.wr ? din_lo : '0;
    if (!ctl.wr)   odd_wdata = '0;
    else if (swap) odd_wdata = din_lo;
    else           odd_wdata = din_hi;
  end

endmodule

// File: rtl/pcl_lane_steer.sv
module pcl_lane_steer
  import pcl_pkg::*;
#(
  parameter  int NPAIR  = 4,
  parameter  int LANE_W = 8,
  localparam int PAIR_W = $clog2(NPAIR),
  localparam int NSEG   = 2 * NPAIR,
  localparam int BUS_W  = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce1_n,
  input  logic              ce2_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              reg_n,
  input  logic              a0,
  input  logic [PAIR_W-1:0] pair_idx,
  input  logic              wp_sw,
  input  logic [BUS_W-1:0]  host_din,
  input  logic [LANE_W-1:0] even_rdata,
  input  logic [LANE_W-1:0] odd_rdata,
  input  logic [LANE_W-1:0] attr_rdata,
  output logic [NSEG-1:0]   seg_sel,
  output logic              attr_sel,
  output logic              wr_en,
  output logic              bus_dir,
  output logic              lane_oe_lo,
  output logic              lane_oe_hi,
  output logic              lane_swap,
  output logic [BUS_W-1:0]  host_dout,
  output logic [LANE_W-1:0] even_wdata,
  output logic [LANE_W-1:0] odd_wdata
);

  acc_ctl_t          acc_ctl;
  logic [NSEG-1:0]   nx_seg_sel;
  logic              nx_oe_lo;
  logic              nx_oe_hi;
  logic              nx_swap;
  logic [BUS_W-1:0]  nx_dout;
  logic [LANE_W-1:0] nx_even_wdata;
  logic [LANE_W-1:0] nx_odd_wdata;

  pcl_mode_dec i_mode_dec (
    .ce1_n (ce1_n),
    .ce2_n (ce2_n),
    .oe_n  (oe_n),
    .we_n  (we_n),
    .reg_n (reg_n),
    .a0    (a0),
    .wp_sw (wp_sw),
    .ctl   (acc_ctl)
  );

  pcl_seg_dec #(.NPAIR(NPAIR)) i_seg_dec (
    .ctl      (acc_ctl),
    .pair_idx (pair_idx),
    .seg_sel  (nx_seg_sel)
  );

  pcl_lane_mux #(.LANE_W(LANE_W)) i_lane_mux (
    .ctl        (acc_ctl),
    .host_din   (host_din),
    .even_rdata (even_rdata),
    .odd_rdata  (odd_rdata),
    .attr_rdata (attr_rdata),
    .oe_lo      (nx_oe_lo),
    .oe_hi      (nx_oe_hi),
    .swap       (nx_swap),
    .dout       (nx_dout),
    .even_wdata (nx_even_wdata),
    .odd_wdata  (nx_odd_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_sel    <= '0;
      attr_sel   <= 1'b0;
      wr_en      <= 1'b0;
      bus_dir    <= 1'b0;
      lane_oe_lo <= 1'b0;
      lane_oe_hi <= 1'b0;
      lane_swap  <= 1'b0;
      host_dout  <= '0;
      even_wdata <= '0;
      odd_wdata  <= '0;
    end else begin
      seg_sel    <= nx_seg_sel;
      attr_sel   <= acc_ctl.attr;
      wr_en      <= acc_ctl.wr;
      bus_dir    <= acc_ctl.rd;
      lane_oe_lo <= nx_oe_lo;
      lane_oe_hi <= nx_oe_hi;
      lane_swap  <= nx_swap;
      host_dout  <= nx_dout;
      even_wdata <= nx_even_wdata;
      odd_wdata  <= nx_odd_wdata;
    end
  end

endmodule

// File: rtl/pcl_lane_steer_chk.sv
module pcl_lane_steer_chk #(
  parameter int NSEG = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ce1_n,
  input logic            ce2_n,
  input logic            oe_n,
  input logic            we_n,
  input logic            reg_n,
  input logic            wp_sw,
  input logic [NSEG-1:0] seg_sel,
  input logic            attr_sel,
  input logic            wr_en,
  input logic            bus_dir,
  input logic            lane_oe_lo,
  input logic            lane_oe_hi,
  input logic            lane_swap
);

  // Set once a clock edge has been taken outside reset, so $past looks at
  // inputs that were really registered.
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  p_standby_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(ce1_n && ce2_n) |->
      (seg_sel == '0) && !attr_sel && !lane_oe_lo && !lane_oe_hi && !wr_en && !lane_swap);

  p_odd_high_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(ce1_n && !ce2_n) |-> !lane_oe_lo && !lane_swap);

  p_sel_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(ce1_n ^ ce2_n) |-> $countones(seg_sel) <= 1);

  p_sel_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seg_sel) <= 2);

  p_attr_no_seg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(!reg_n) |-> (seg_sel == '0) && !lane_oe_hi && !lane_swap);

  p_attr_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(attr_sel && (seg_sel != '0)));

  p_oe_high_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(oe_n) |-> !lane_oe_lo && !lane_oe_hi && !bus_dir);

  p_protect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(wp_sw) |-> !wr_en);

  p_strobe_clash_r11: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(!oe_n && !we_n) |->
      (seg_sel == '0) && !attr_sel && !wr_en && !lane_oe_lo && !lane_oe_hi);

  p_dir_vs_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_dir && wr_en));

endmodule

bind pcl_lane_steer pcl_lane_steer_chk #(.NSEG(NSEG)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ce1_n      (ce1_n),
  .ce2_n      (ce2_n),
  .oe_n       (oe_n),
  .we_n       (we_n),
  .reg_n      (reg_n),
  .wp_sw      (wp_sw),
  .seg_sel    (seg_sel),
  .attr_sel   (attr_sel),
  .wr_en      (wr_en),
  .bus_dir    (bus_dir),
  .lane_oe_lo (lane_oe_lo),
  .lane_oe_hi (lane_oe_hi),
  .lane_swap  (lane_swap)
);

// File: tb/test_pcl_lane_steer.sv
module test_pcl_lane_steer;

  localparam int CLK_PERIOD = 10;
  localparam int NPAIR = 4;
  localparam int LANE_W = 8;
  localparam int PAIR_W = 2;
  localparam int NSEG = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce1_n = 1'b1, ce2_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, reg_n = 1'b1;
  logic a0 = 1'b0, wp_sw = 1'b0;
  logic [PAIR_W-1:0] pair_idx = '0;
  logic [15:0] host_din = '0;
  logic [7:0]  even_rdata = '0, odd_rdata = '0, attr_rdata = '0;
  logic [NSEG-1:0] seg_sel;
  logic attr_sel, wr_en, bus_dir, lane_oe_lo, lane_oe_hi, lane_swap;
  logic [15:0] host_dout;
  logic [7:0]  even_wdata, odd_wdata;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcl_lane_steer #(.NPAIR(NPAIR), .LANE_W(LANE_W)) i_pcl_lane_steer (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2_n(ce2_n), .oe_n(oe_n),
    .we_n(we_n), .reg_n(reg_n), .a0(a0), .pair_idx(pair_idx), .wp_sw(wp_sw),
    .host_din(host_din), .even_rdata(even_rdata), .odd_rdata(odd_rdata),
    .attr_rdata(attr_rdata), .seg_sel(seg_sel), .attr_sel(attr_sel),
    .wr_en(wr_en), .bus_dir(bus_dir), .lane_oe_lo(lane_oe_lo),
    .lane_oe_hi(lane_oe_hi), .lane_swap(lane_swap), .host_dout(host_dout),
    .even_wdata(even_wdata), .odd_wdata(odd_wdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Independent reference values for the current stimulus.
  logic e_sel_any, e_clash, e_word, e_oddhi, e_oddsw, e_even, e_attr, e_valid;
  logic e_rd, e_wr, e_oe_lo, e_oe_hi, e_swap, e_attr_sel;
  logic [NSEG-1:0] e_seg;
  logic [15:0] e_dout;
  logic [7:0]  e_ewd, e_owd;
  string mtag;

  task automatic compute();
    e_sel_any = !(ce1_n && ce2_n);
    e_clash   = !oe_n && !we_n;
    e_word    = !ce1_n && !ce2_n;
    e_oddhi   = ce1_n && !ce2_n;
    e_oddsw   = !ce1_n && ce2_n && a0;
    e_even    = !ce1_n && ce2_n && !a0;
    e_attr    = !reg_n;
    e_valid   = e_sel_any && !e_clash && !(e_attr && (e_oddhi || e_oddsw));
    e_rd      = e_valid && !oe_n && we_n;
    e_wr      = e_valid && oe_n && !we_n && !wp_sw;
    e_seg     = '0;
    if (e_valid && !e_attr) begin
      if (e_even || e_word)             e_seg[2*pair_idx]   = 1'b1;
      if (e_oddhi || e_oddsw || e_word) e_seg[2*pair_idx+1] = 1'b1;
    end
    e_attr_sel = e_valid && e_attr;
    e_oe_lo   = e_rd && !e_oddhi;
    e_oe_hi   = e_rd && !e_attr && (e_oddhi || e_word);
    e_swap    = e_valid && !e_attr && e_oddsw;
    e_dout    = '0;
    if (e_oe_lo) e_dout[7:0] = e_swap ? odd_rdata : (e_attr ? attr_rdata : even_rdata);
    if (e_oe_hi) e_dout[15:8] = odd_rdata;
    e_ewd = e_wr ? host_din[7:0] : 8'h00;
    e_owd = e_wr ? (e_swap ? host_din[7:0] : host_din[15:8]) : 8'h00;
    if (!e_sel_any)   mtag = "R1";
    else if (e_clash) mtag = "R11";
    else if (e_attr)  mtag = "R8";
    else if (e_word)  mtag = "R5";
    else if (e_oddhi) mtag = "R4";
    else if (e_oddsw) mtag = "R3";
    else              mtag = "R2";
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R12: reset clears outputs even with a word read presented
    ce1_n = 1'b0; ce2_n = 1'b0; oe_n = 1'b0; even_rdata = 8'h5A; odd_rdata = 8'hA5;
    tick(); tick();
    chk("R12 reset seg_sel", 32'(seg_sel), 0);
    chk("R12 reset lane_oe_hi", 32'(lane_oe_hi), 0);
    chk("R12 reset host_dout", 32'(host_dout), 0);
    rst_n = 1'b1;
    tick();
    chk("R5 word read after reset", 32'(host_dout), 32'hA55A);
    // R12: outputs hold until the next edge
    ce1_n = 1'b1; ce2_n = 1'b1;
    #2;
    chk("R12 hold between edges", 32'(lane_oe_hi), 1);
    tick();
    chk("R12 standby after edge", 32'(lane_oe_hi), 0);

    for (int i = 0; i < 512; i++) begin
      {ce1_n, ce2_n, oe_n, we_n, reg_n, a0, pair_idx, wp_sw} = i[8:0];
      even_rdata = i[7:0] ^ 8'h5A;
      odd_rdata  = ~i[7:0];
      attr_rdata = i[7:0] + 8'h33;
      host_din   = {i[7:0] ^ 8'hC3, i[7:0] + 8'h01};
      compute();
      tick();
      chk({mtag, " seg_sel"}, 32'(seg_sel), 32'(e_seg));
      chk("R8 attr_sel", 32'(attr_sel), 32'(e_attr_sel));
      chk(oe_n ? "R9 lane_oe_lo" : {mtag, " lane_oe_lo"}, 32'(lane_oe_lo), 32'(e_oe_lo));
      chk(oe_n ? "R9 lane_oe_hi" : {mtag, " lane_oe_hi"}, 32'(lane_oe_hi), 32'(e_oe_hi));
      chk("R3 lane_swap", 32'(lane_swap), 32'(e_swap));
      chk("R9 bus_dir", 32'(bus_dir), 32'(e_rd));
      chk("R10 wr_en", 32'(wr_en), 32'(e_wr));
      chk({mtag, " host_dout"}, 32'(host_dout), 32'(e_dout));
      chk("R10 even_wdata", 32'(even_wdata), 32'(e_ewd));
      chk("R10 odd_wdata", 32'(odd_wdata), 32'(e_owd));
      // R6: nothing outside the addressed pair
      chk("R6 pair confined", 32'(seg_sel & ~(8'b11 << (2*pair_idx))), 0);
      // R7: one select for a byte, two for a word
      if (e_valid && !e_attr)
        chk("R7 select count", 32'($countones(seg_sel)), e_word ? 2 : 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule